// File: doc/BRIEF.md
# Console Serial Line Command Port

This block is the programmed-I/O side of a console serial controller. A processor issues one command per cycle: a class (control pulse, skip test, input to accumulator, output from accumulator) and a 4-bit function code. A command may carry the accumulator value. One cycle later the block returns a response strobe, a skip/success bit and the accumulator value that results. The block holds the line direction mode, the interrupt masks and DMA enables for each direction, the receive holding byte with its error flags, the transmit holding byte, and eight general 16-bit registers. These registers are two control registers per direction, a DMA channel address per direction and an interrupt vector per direction.

On the character side, the block takes received bytes from a serializer as a valid/data pair with parity and framing error flags. It offers transmit bytes on a valid/data pair that waits for a ready. In self-test mode a transmitted byte does not go to the line. It lands in the receive holding register instead. Interrupt request outputs are the mask ANDed with the matching ready condition. The DMA enables go out as plain levels for an external engine.

Function codes below are written in octal.

Top module: `conio_front`

## Requirements
- R1: Every command with cmdValid high gives rspValid high in the next cycle, and control-class commands (class 0) never skip. Class encoding: 0 control, 1 skip test, 2 input, 3 output.
- R2: Control 00 selects input-only mode and control 01 selects output-only mode. Control 10 (full duplex) and control 12 (normal) enable both directions. Skip test 00 succeeds on receive-ready in input-only mode, on transmit-free in output-only mode, and on either condition otherwise.
- R3: Control 02, 03 and 04 set the receive interrupt mask, set the receive DMA enable, and clear both of them. Control 05, 06 and 07 do the same for transmit. Control 15 sets both masks and control 16 clears both. rxIrq equals the receive mask AND receive-ready. txIrq equals the transmit mask AND transmit-free.
- R4: Reset and control 17 both give input-only mode with all masks and DMA enables cleared.
- R5: Control 13 enters self-test mode. In this mode a successful output 00 places the byte into the receive holding register and leaves txValid low.
- R6: Skip 06 succeeds when no transmit byte is pending. Skip 01 succeeds when the transmitter is not busy. Skip 07 succeeds when a received byte is present. Skip 02 succeeds when the receiver is not interrupting, skip 05 when the transmitter is not interrupting, and skip 04 when neither is. Skip 03 always succeeds.
- R7: Skip 15 succeeds on a parity error, skip 16 on an overrun, and skip 17 on a framing error.
- R8: When a byte is present, input 00 ORs it into the low byte of the accumulator and keeps the high byte, and input 10 returns the byte zero-extended. Either one skips and consumes the byte. With no byte present, neither one skips and the accumulator comes back unchanged.
- R9: A byte that arrives while the previous one is still unconsumed raises the overrun flag. Consuming a byte clears the parity, framing and overrun flags.
- R10: Input 11 returns the device identifier 4 and skips.
- R11: Output 00 presents the low 8 accumulator bits on txData with txValid, which is held until txReady, and skips. It fails without a skip in input-only mode or while a byte is still pending.
- R12: Input and output functions 04–07 and 14–17 access eight independent 16-bit registers and always skip. A read returns the last value written to that function.
- R13: Any unimplemented class/function pair does not skip, returns the accumulator unchanged and changes no state. Examples are control 11 and 14, skip 10–14, input 02 and output 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdClass | input | 2 | Command class |
| cmdFunc | input | 4 | Function code |
| accIn | input | 16 | Accumulator value with the command |
| rspValid | output | 1 | Response strobe, one cycle after the command |
| rspSkip | output | 1 | Success/skip indication |
| accOut | output | 16 | Resulting accumulator value |
| rxValid | input | 1 | Received byte strobe from the serializer |
| rxData | input | 8 | Received byte |
| rxParErr | input | 1 | Parity error with the received byte |
| rxFrmErr | input | 1 | Framing error with the received byte |
| txValid | output | 1 | Transmit byte pending |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Serializer accepts the transmit byte |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| rxDmaEn | output | 1 | Receive DMA enable |
| txDmaEn | output | 1 | Transmit DMA enable |

## Verification
A command sampled at one rising edge has its response (rspValid, rspSkip, accOut) registered at that same edge. Its state effects, such as masks, DMA enables, txValid and the receive flags, are visible right after that edge as well. A received byte likewise becomes present one edge after rxValid. The driver presents each command at a falling edge and holds it for one cycle. The scoreboard monitor pops the expected response at the following falling edge. Direct port checks on the interrupt, DMA and transmit outputs are made at that falling edge too, so every check samples half a cycle clear of the edge that produced the value.

// File: rtl/conio_pkg.sv
package conio_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [1:0] {CLS_CTRL = 2'd0, CLS_SKIP = 2'd1, CLS_IN = 2'd2, CLS_OUT = 2'd3} cls_e;

  typedef enum logic [2:0] {
    MODE_RXONLY = 3'd0, MODE_TXONLY = 3'd1, MODE_DUPLEX = 3'd2,
    MODE_NORMAL = 3'd3, MODE_LOOP   = 3'd4
  } mode_e;

  typedef struct packed {
    logic                 done;
    logic                 skip;
    logic                 setMode;
    mode_e                modeVal;
    logic                 masterClr;
    logic                 rxMaskSet;
    logic                 rxMaskClr;
    logic                 rxDmaSet;
    logic                 rxDmaClr;
    logic                 txMaskSet;
    logic                 txMaskClr;
    logic                 txDmaSet;
    logic                 txDmaClr;
    logic                 rdChar;
    logic                 clrAcc;
    logic                 rdReg;
    logic                 wrReg;
    logic                 rdId;
    logic                 sendChar;
    logic [REG_IDX_W-1:0] regIdx;
  } strobe_t;

  typedef struct packed {
    mode_e mode;
    logic  rxReady;
    logic  txBusy;
    logic  rxIrq;
    logic  txIrq;
    logic  parErr;
    logic  ovrErr;
    logic  frmErr;
  } status_t;
endpackage

// File: rtl/conio_ctl.sv
module conio_ctl
  import conio_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic [1:0] cmdClass,
  input  logic [3:0] cmdFunc,
  input  status_t stat,
  output strobe_t strb
);
  always_comb begin
    strb = '0;
    strb.modeVal = MODE_RXONLY;
    strb.regIdx = {cmdFunc[3], cmdFunc[1:0]};
    if (cmdValid) begin
      strb.done = 1'b1;
      unique case (cls_e'(cmdClass))
        CLS_CTRL: begin
          case (cmdFunc)
            4'o00: begin strb.setMode = 1'b1; strb.modeVal = MODE_RXONLY; end
            4'o01: begin strb.setMode = 1'b1; strb.modeVal = MODE_TXONLY; end
            4'o02: strb.rxMaskSet = 1'b1;
            4'o03: strb.rxDmaSet = 1'b1;
            4'o04: begin strb.rxMaskClr = 1'b1; strb.rxDmaClr = 1'b1; end
            4'o05: strb.txMaskSet = 1'b1;
            4'o06: strb.txDmaSet = 1'b1;
            4'o07: begin strb.txMaskClr = 1'b1; strb.txDmaClr = 1'b1; end
            4'o10: begin strb.setMode = 1'b1; strb.modeVal = MODE_DUPLEX; end
            4'o12: begin strb.setMode = 1'b1; strb.modeVal = MODE_NORMAL; end
            4'o13: begin strb.setMode = 1'b1; strb.modeVal = MODE_LOOP; end
            4'o15: begin strb.rxMaskSet = 1'b1; strb.txMaskSet = 1'b1; end
            4'o16: begin strb.rxMaskClr = 1'b1; strb.txMaskClr = 1'b1; end
            4'o17: strb.masterClr = 1'b1;
            default: ;
          endcase
        end
        CLS_SKIP: begin
          case (cmdFunc)
            4'o00: strb.skip = (stat.mode == MODE_RXONLY) ? stat.rxReady :
                               (stat.mode == MODE_TXONLY) ? !stat.txBusy :
                               (stat.rxReady || !stat.txBusy);
            4'o01, 4'o06: strb.skip = !stat.txBusy;
            4'o02: strb.skip = !stat.rxIrq;
            4'o03: strb.skip = 1'b1;
            4'o04: strb.skip = !stat.rxIrq && !stat.txIrq;
            4'o05: strb.skip = !stat.txIrq;
            4'o07: strb.skip = stat.rxReady;
            4'o15: strb.skip = stat.parErr;
            4'o16: strb.skip = stat.ovrErr;
            4'o17: strb.skip = stat.frmErr;
            default: ;
          endcase
        end
        CLS_IN: begin
          case (cmdFunc)
            4'o00, 4'o10: if (stat.rxReady) begin
              strb.rdChar = 1'b1;
              strb.clrAcc = cmdFunc[3];
              strb.skip = 1'b1;
            end
            4'o04, 4'o05, 4'o06, 4'o07, 4'o14, 4'o15, 4'o16, 4'o17: begin
              strb.rdReg = 1'b1;
              strb.skip = 1'b1;
            end
            4'o11: begin strb.rdId = 1'b1; strb.skip = 1'b1; end
            default: ;
          endcase
        end
        CLS_OUT: begin
          case (cmdFunc)
            4'o00: if (stat.mode != MODE_RXONLY && !stat.txBusy) begin
              strb.sendChar = 1'b1;
              strb.skip = 1'b1;
            end
            4'o04, 4'o05, 4'o06, 4'o07, 4'o14, 4'o15, 4'o16, 4'o17: begin
              strb.wrReg = 1'b1;
              strb.skip = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  // R2 / R11: an output in input-only mode never launches a byte
  p_out_blocked_rxonly_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdClass == 2'd3 && stat.mode == MODE_RXONLY) |-> !strb.sendChar);
  // R11: no second byte while one is pending
  p_no_double_send_r11: assert property (@(posedge clk) disable iff (!rstN)
    stat.txBusy |-> !strb.sendChar);
endmodule

// File: rtl/conio_dp.sv
module conio_dp
  import conio_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int CHAR_W = 8,
  parameter int DEV_ID = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ACC_W-1:0]  accIn,
  output status_t           stat,
  output logic              rspValid,
  output logic              rspSkip,
  output logic [ACC_W-1:0]  accOut,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              rxDmaEn,
  output logic              txDmaEn
);
  localparam int NREG = 1 << REG_IDX_W;
  localparam int HI_W = ACC_W - CHAR_W;

  mode_e modeQ;
  logic rxMaskQ, txMaskQ, rxDmaQ, txDmaQ;
  logic rxReadyQ, parQ, ovrQ, frmQ, txPend;
  logic [CHAR_W-1:0] rxBuf, txBuf;
  logic [ACC_W-1:0] regFile [NREG];

  // receive source: loopback in self-test, line otherwise
  logic loopMode, lbValid, inValid, inPar, inFrm;
  logic [CHAR_W-1:0] inData;
  assign loopMode = (modeQ == MODE_LOOP);
  assign lbValid  = strb.sendChar && loopMode;
  assign inValid  = lbValid || (rxValid && !loopMode);
  assign inData   = lbValid ? accIn[CHAR_W-1:0] : rxData;
  assign inPar    = !lbValid && rxParErr;
  assign inFrm    = !lbValid && rxFrmErr;

  always_ff @(posedge clk) begin
    if (!rstN || strb.masterClr) begin
      modeQ <= MODE_RXONLY;
      rxMaskQ <= 1'b0; txMaskQ <= 1'b0;
      rxDmaQ <= 1'b0;  txDmaQ <= 1'b0;
    end else begin
      if (strb.setMode) modeQ <= strb.modeVal;
      if (strb.rxMaskSet) rxMaskQ <= 1'b1; else if (strb.rxMaskClr) rxMaskQ <= 1'b0;
      if (strb.txMaskSet) txMaskQ <= 1'b1; else if (strb.txMaskClr) txMaskQ <= 1'b0;
      if (strb.rxDmaSet)  rxDmaQ  <= 1'b1; else if (strb.rxDmaClr)  rxDmaQ  <= 1'b0;
      if (strb.txDmaSet)  txDmaQ  <= 1'b1; else if (strb.txDmaClr)  txDmaQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReadyQ <= 1'b0; parQ <= 1'b0; ovrQ <= 1'b0; frmQ <= 1'b0;
      rxBuf <= '0;
    end else begin
      rxReadyQ <= inValid || (rxReadyQ && !strb.rdChar);
      if (inValid) begin
        rxBuf <= inData;
        parQ  <= (parQ && !strb.rdChar) || inPar;
        frmQ  <= (frmQ && !strb.rdChar) || inFrm;
        ovrQ  <= (ovrQ && !strb.rdChar) || (rxReadyQ && !strb.rdChar);
      end else if (strb.rdChar) begin
        parQ <= 1'b0; frmQ <= 1'b0; ovrQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPend <= 1'b0;
      txBuf <= '0;
    end else if (strb.sendChar && !loopMode) begin
      txPend <= 1'b1;
      txBuf <= accIn[CHAR_W-1:0];
    end else if (txPend && txReady) begin
      txPend <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : gRegs
    always_ff @(posedge clk) begin
      if (!rstN) regFile[g] <= '0;
      else if (strb.wrReg && strb.regIdx == REG_IDX_W'(g)) regFile[g] <= accIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspSkip <= 1'b0; accOut <= '0;
    end else begin
      rspValid <= strb.done;
      rspSkip  <= strb.skip;
      if (strb.rdChar)
        accOut <= strb.clrAcc ? {{HI_W{1'b0}}, rxBuf}
                              : {accIn[ACC_W-1:CHAR_W], accIn[CHAR_W-1:0] | rxBuf};
      else if (strb.rdReg) accOut <= regFile[strb.regIdx];
      else if (strb.rdId)  accOut <= ACC_W'(DEV_ID);
      else                 accOut <= accIn;
    end
  end

  assign txValid = txPend;
  assign txData  = txBuf;
  assign rxIrq   = rxMaskQ && rxReadyQ;
  assign txIrq   = txMaskQ && !txPend;
  assign rxDmaEn = rxDmaQ;
  assign txDmaEn = txDmaQ;

  assign stat.mode    = modeQ;
  assign stat.rxReady = rxReadyQ;
  assign stat.txBusy  = txPend;
  assign stat.rxIrq   = rxIrq;
  assign stat.txIrq   = txIrq;
  assign stat.parErr  = parQ;
  assign stat.ovrErr  = ovrQ;
  assign stat.frmErr  = frmQ;

  p_rsp_next_cycle_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> rspValid);
  p_mclr_state_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.masterClr |=> (modeQ == MODE_RXONLY && !rxMaskQ && !txMaskQ && !rxDmaQ && !txDmaQ));
  p_loop_no_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lbValid && !txPend) |=> (rxReadyQ && !txPend));
  p_consume_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdChar && !inValid) |=> !rxReadyQ);
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxReadyQ && inValid && !strb.rdChar) |=> ovrQ);
  p_dev_id_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdId |=> (accOut == ACC_W'(DEV_ID) && rspSkip));
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txPend && !txReady) |=> (txPend && $stable(txBuf)));
endmodule

// File: rtl/conio_front.sv
module conio_front
  import conio_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int CHAR_W = 8,
  parameter int DEV_ID = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdClass,
  input  logic [3:0]        cmdFunc,
  input  logic [ACC_W-1:0]  accIn,
  output logic              rspValid,
  output logic              rspSkip,
  output logic [ACC_W-1:0]  accOut,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              rxDmaEn,
  output logic              txDmaEn
);
  strobe_t strb;
  status_t stat;

  conio_ctl uCtl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdClass(cmdClass),
    .cmdFunc(cmdFunc), .stat(stat), .strb(strb)
  );

  conio_dp #(.ACC_W(ACC_W), .CHAR_W(CHAR_W), .DEV_ID(DEV_ID)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .accIn(accIn), .stat(stat),
    .rspValid(rspValid), .rspSkip(rspSkip), .accOut(accOut),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxDmaEn(rxDmaEn), .txDmaEn(txDmaEn)
  );
endmodule

// File: tb/conio_front_test.sv
module conio_front_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdClass = '0;
  logic [3:0] cmdFunc = '0;
  logic [15:0] accIn = '0;
  logic rspValid, rspSkip, txValid, rxIrq, txIrq, rxDmaEn, txDmaEn;
  logic [15:0] accOut;
  logic rxValid = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0, txReady = 1'b0;
  logic [7:0] rxData = '0;
  logic [7:0] txData;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  logic [16:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  conio_front uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdClass(cmdClass), .cmdFunc(cmdFunc),
    .accIn(accIn), .rspValid(rspValid), .rspSkip(rspSkip), .accOut(accOut),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxIrq(rxIrq), .txIrq(txIrq), .rxDmaEn(rxDmaEn), .txDmaEn(txDmaEn)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: response due one edge after the command
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) chk(1'b0, "R1 unexpected response", 32'(accOut), 0);
      else begin
        logic [16:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rspSkip == e[16], {t, " skip"}, 32'(rspSkip), 32'(e[16]));
        chk(accOut == e[15:0], {t, " acc"}, 32'(accOut), 32'(e[15:0]));
      end
    end
  end

  task automatic issue(input logic [1:0] cls, input logic [3:0] fn, input logic [15:0] acc,
                       input logic expSkip, input logic [15:0] expAcc, input string tag);
    @(negedge clk);
    expQ.push_back({expSkip, expAcc});
    tagQ.push_back(tag);
    cmdValid = 1'b1; cmdClass = cls; cmdFunc = fn; accIn = acc;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic ctl(input logic [3:0] fn, input string tag);
    issue(2'd0, fn, 16'h5a5a, 1'b0, 16'h5a5a, tag);
  endtask

  task automatic sks(input logic [3:0] fn, input logic expSkip, input string tag);
    issue(2'd1, fn, 16'h0101, expSkip, 16'h0101, tag);
  endtask

  task automatic rxByte(input logic [7:0] d, input logic par, input logic frm);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxParErr = par; rxFrmErr = frm;
    @(negedge clk);
    rxValid = 1'b0; rxParErr = 1'b0; rxFrmErr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk(!txValid && !rxIrq && !txIrq && !rxDmaEn && !txDmaEn && !rspValid, "R4 reset outputs",
        {txValid, rxIrq, txIrq, rxDmaEn, txDmaEn, rspValid}, 0);
    sks(4'o07, 1'b0, "R6 no rx byte");
    sks(4'o06, 1'b1, "R6 tx free");
    sks(4'o03, 1'b1, "R6 regs valid");
    sks(4'o00, 1'b0, "R2 skip00 rx-only no byte");
    // R2 / R11 output blocked in input-only mode
    issue(2'd3, 4'o00, 16'h0041, 1'b0, 16'h0041, "R11 out in rx-only");
    chk(!txValid, "R2 no tx in rx-only", 32'(txValid), 0);
    ctl(4'o01, "R1 ctrl no skip");
    sks(4'o00, 1'b1, "R2 skip00 tx-only tx free");
    issue(2'd3, 4'o00, 16'h1241, 1'b1, 16'h1241, "R11 send");
    chk(txValid && txData == 8'h41, "R11 tx byte", {txValid, txData}, {1'b1, 8'h41});
    sks(4'o06, 1'b0, "R6 tx busy");
    sks(4'o01, 1'b0, "R6 busy");
    issue(2'd3, 4'o00, 16'h0042, 1'b0, 16'h0042, "R11 send while pending");
    chk(txValid && txData == 8'h41, "R11 tx held", {txValid, txData}, {1'b1, 8'h41});
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    chk(!txValid, "R11 tx accepted", 32'(txValid), 0);
    // R8 byte merge and clear
    rxByte(8'h5a, 1'b0, 1'b0);
    sks(4'o07, 1'b1, "R6 rx byte present");
    issue(2'd2, 4'o00, 16'hab0f, 1'b1, 16'hab5f, "R8 or-merge");
    sks(4'o07, 1'b0, "R8 consumed");
    issue(2'd2, 4'o10, 16'h7777, 1'b0, 16'h7777, "R8 no byte");
    // R9 / R7 overrun and parity
    rxByte(8'h33, 1'b0, 1'b0);
    rxByte(8'h44, 1'b1, 1'b0);
    sks(4'o16, 1'b1, "R9 overrun");
    sks(4'o15, 1'b1, "R7 parity");
    sks(4'o17, 1'b0, "R7 no framing");
    issue(2'd2, 4'o10, 16'hffff, 1'b1, 16'h0044, "R8 clear load");
    sks(4'o16, 1'b0, "R9 overrun cleared");
    sks(4'o15, 1'b0, "R9 parity cleared");
    rxByte(8'h10, 1'b0, 1'b1);
    sks(4'o17, 1'b1, "R7 framing");
    issue(2'd2, 4'o00, 16'h8001, 1'b1, 16'h8011, "R8 or-merge high kept");
    // R10
    issue(2'd2, 4'o11, 16'h1234, 1'b1, 16'h0004, "R10 device id");
    // R12 register file
    for (int i = 0; i < 8; i++) begin
      logic [3:0] f;
      f = (i < 4) ? 4'(4 + i) : 4'(8 + i);
      issue(2'd3, f, 16'h1000 + 16'(i * 'h111), 1'b1, 16'h1000 + 16'(i * 'h111), "R12 write");
    end
    for (int i = 0; i < 8; i++) begin
      logic [3:0] f;
      f = (i < 4) ? 4'(4 + i) : 4'(8 + i);
      issue(2'd2, f, 16'h0000, 1'b1, 16'h1000 + 16'(i * 'h111), "R12 read back");
    end
    // R3 masks and DMA
    ctl(4'o12, "R2 normal mode");
    ctl(4'o02, "R3 rx mask");
    chk(!rxIrq, "R3 rx mask no byte", 32'(rxIrq), 0);
    rxByte(8'h21, 1'b0, 1'b0);
    chk(rxIrq, "R3 rx irq", 32'(rxIrq), 1);
    sks(4'o02, 1'b0, "R6 rx interrupting");
    sks(4'o04, 1'b0, "R6 some interrupting");
    sks(4'o00, 1'b1, "R2 skip00 both dirs");
    ctl(4'o05, "R3 tx mask");
    chk(txIrq, "R3 tx irq", 32'(txIrq), 1);
    sks(4'o05, 1'b0, "R6 tx interrupting");
    ctl(4'o16, "R3 clear both masks");
    chk(!rxIrq && !txIrq, "R3 both clear", {rxIrq, txIrq}, 0);
    ctl(4'o15, "R3 set both masks");
    chk(rxIrq && txIrq, "R3 both set", {rxIrq, txIrq}, 3);
    ctl(4'o03, "R3 rx dma");
    ctl(4'o06, "R3 tx dma");
    chk(rxDmaEn && txDmaEn, "R3 dma on", {rxDmaEn, txDmaEn}, 3);
    ctl(4'o04, "R3 rx clear");
    chk(!rxDmaEn && !rxIrq && txIrq && txDmaEn, "R3 rx side cleared",
        {rxDmaEn, rxIrq, txIrq, txDmaEn}, 4'b0011);
    ctl(4'o07, "R3 tx clear");
    chk(!txDmaEn && !txIrq, "R3 tx side cleared", {txDmaEn, txIrq}, 0);
    ctl(4'o15, "R3 masks again");
    ctl(4'o03, "R3 rx dma again");
    ctl(4'o06, "R3 tx dma again");
    // R13 unimplemented
    ctl(4'o11, "R13 ctrl 11");
    ctl(4'o14, "R13 ctrl 14");
    chk(rxIrq && txIrq && rxDmaEn && txDmaEn, "R13 state kept",
        {rxIrq, txIrq, rxDmaEn, txDmaEn}, 4'hf);
    issue(2'd2, 4'o02, 16'hbeef, 1'b0, 16'hbeef, "R13 input 02");
    sks(4'o12, 1'b0, "R13 skip 12");
    issue(2'd3, 4'o01, 16'h00aa, 1'b0, 16'h00aa, "R13 output 01");
    chk(!txValid, "R13 no tx", 32'(txValid), 0);
    sks(4'o07, 1'b1, "R13 rx byte kept");
    // R4 master clear
    ctl(4'o17, "R4 master clear");
    chk(!rxIrq && !txIrq && !rxDmaEn && !txDmaEn, "R4 cleared",
        {rxIrq, txIrq, rxDmaEn, txDmaEn}, 0);
    issue(2'd3, 4'o00, 16'h0055, 1'b0, 16'h0055, "R4 rx-only after clear");
    issue(2'd2, 4'o10, 16'h0000, 1'b1, 16'h0021, "R8 drain");
    // R5 self-test loopback
    ctl(4'o13, "R5 self test");
    issue(2'd3, 4'o00, 16'h1277, 1'b1, 16'h1277, "R5 loop send");
    chk(!txValid, "R5 line quiet", 32'(txValid), 0);
    sks(4'o07, 1'b1, "R5 looped byte present");
    issue(2'd2, 4'o10, 16'hffff, 1'b1, 16'h0077, "R5 looped byte");
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R1 all responses seen", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule